// File: doc/BRIEF.md
# Effective Address Unit

This block works out where the operand of a load-to-accumulator comes from, and then fetches that operand. A start strobe hands it a 4-bit mode code, the instruction's address field, the program counter, an index register, one selected general register and the current accumulator. The unit forms the effective address and, when the mode needs one, runs one or two reads on a single request/ready memory port. It then returns the address and the operand with a one-cycle done pulse.

The program counter is taken as given. It has already advanced past the current instruction, so a two-word instruction at 200 arrives with 202. In the auto-stepping modes the unit also returns a write-back for the selected register, as an enable and a value that travel with the done pulse. All address arithmetic wraps modulo 2^AW (AW defaults to 12). Data words are DW bits wide, with DW no smaller than AW. An address taken from a data word uses its low AW bits.

Top module: `ea_unit`

## Requirements
- R1: After reset, done, busy, mem_req and reg_we are all low.
- R2: Modes that read no memory are implied (code 0), immediate (code 1) and register (code 2). For these, done rises in the cycle after the accepted start, mem_req stays low and ea is 0. The operand is acc for implied, the zero-extended address field for immediate, and sel_reg for register.
- R3: Direct mode (code 6) uses the address field as the effective address. Register indirect (code 3) uses the low AW bits of sel_reg. Each makes exactly one read, and the operand is the word read at ea.
- R4: Indirect mode (code 7) first reads the word at the address field. The low AW bits of that word become ea, and a second read at ea gives the operand, for two reads in total.
- R5: Relative mode (code 8) sets ea = pc + address field modulo 2^AW, then makes one read.
- R6: Indexed mode (code 9) sets ea = index_reg + address field modulo 2^AW, then makes one read.
- R7: Autoincrement (code 4) uses sel_reg as ea and returns reg_wdata = sel_reg + 1. Autodecrement (code 5) uses sel_reg - 1 as both ea and reg_wdata. In both modes reg_we is high in the done cycle. In every other mode reg_we stays low, and reg_we is never high outside a done cycle.
- R8: Once raised, mem_req stays high with mem_addr unchanged until a cycle in which mem_ready is high. mem_rdata is taken in that same cycle, whatever the number of wait cycles.
- R9: done is a single-cycle pulse, and ea and operand are valid with it. busy is high from the cycle after a memory-mode start until done.
- R10: A start that arrives while busy is high is ignored. Mode codes 10 to 15 behave as implied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, sampled while idle |
| mode | input | 4 | Addressing mode code |
| addr_field | input | AW | Address field of the instruction |
| pc | input | AW | Program counter, already advanced |
| index_reg | input | AW | Index register |
| sel_reg | input | DW | Selected general register |
| acc | input | DW | Current accumulator |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ready | input | 1 | Read data valid / request accepted |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | Memory fetch in progress |
| done | output | 1 | Result valid pulse |
| ea | output | AW | Effective address |
| operand | output | DW | Loaded operand |
| reg_we | output | 1 | Selected-register write-back enable |
| reg_wdata | output | DW | Selected-register write-back value |

## Verification
The assertions assume that mem_ready is raised only while mem_req is high and that mem_rdata is valid in the same cycle. They also assume that the mode and operand inputs matter only in the cycle that start is accepted. The bench's memory model follows these rules. It answers each request after a wait count that each operation sets (zero to six cycles), and its data is a computed function of the address. The bench changes mode, the address field and the start strobe in the middle of a fetch, so that the capture-at-start rule is exercised and not merely assumed.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam logic [3:0] M_IMPLIED  = 4'd0;
    localparam logic [3:0] M_IMMED    = 4'd1;
    localparam logic [3:0] M_REG      = 4'd2;
    localparam logic [3:0] M_REGIND   = 4'd3;
    localparam logic [3:0] M_AUTOINC  = 4'd4;
    localparam logic [3:0] M_AUTODEC  = 4'd5;
    localparam logic [3:0] M_DIRECT   = 4'd6;
    localparam logic [3:0] M_INDIRECT = 4'd7;
    localparam logic [3:0] M_RELATIVE = 4'd8;
    localparam logic [3:0] M_INDEXED  = 4'd9;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PTR  = 2'd1,
        S_OPND = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] field,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] regv,
    input  logic [DW-1:0] acc,
    output logic [AW-1:0] calc_ea,
    output logic [DW-1:0] calc_opnd,
    output logic          need_mem,
    output logic          need_ptr,
    output logic          wb_en,
    output logic [DW-1:0] wb_data
);
    logic [DW-1:0] reg_inc;
    logic [DW-1:0] reg_dec;

    assign reg_inc = regv + DW'(1);
    assign reg_dec = regv - DW'(1);

    always_comb begin
        calc_ea   = '0;
        calc_opnd = acc;
        need_mem  = 1'b0;
        need_ptr  = 1'b0;
        wb_en     = 1'b0;
        wb_data   = regv;
        case (mode)
            M_IMMED:  calc_opnd = DW'(field);
            M_REG:    calc_opnd = regv;
            M_REGIND: begin
                calc_ea  = regv[AW-1:0];
                need_mem = 1'b1;
            end
            M_AUTOINC: begin
                calc_ea  = regv[AW-1:0];
                need_mem = 1'b1;
                wb_en    = 1'b1;
                wb_data  = reg_inc;
            end
            M_AUTODEC: begin
                calc_ea  = reg_dec[AW-1:0];
                need_mem = 1'b1;
                wb_en    = 1'b1;
                wb_data  = reg_dec;
            end
            M_DIRECT: begin
                calc_ea  = field;
                need_mem = 1'b1;
            end
            M_INDIRECT: begin
                calc_ea  = field;
                need_mem = 1'b1;
                need_ptr = 1'b1;
            end
            M_RELATIVE: begin
                calc_ea  = pc + field;
                need_mem = 1'b1;
            end
            M_INDEXED: begin
                calc_ea  = idx + field;
                need_mem = 1'b1;
            end
            default: calc_opnd = acc;
        endcase
    end

    always_comb begin
        if (!need_mem) assert_nomem_no_wb_R7: assert (!wb_en);
        if (need_ptr)  assert_ptr_is_mem_R4: assert (need_mem);
    end
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] calc_ea,
    input  logic [DW-1:0] calc_opnd,
    input  logic          need_mem,
    input  logic          need_ptr,
    input  logic          wb_en,
    input  logic [DW-1:0] wb_data,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [DW-1:0] operand,
    output logic          reg_we,
    output logic [DW-1:0] reg_wdata
);
    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] ea;
        logic [DW-1:0] opnd;
        logic [DW-1:0] wdata;
        logic          we_pend;
        logic          we;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.we   = 1'b0;
        case (seq_q.st)
            S_IDLE: begin
                if (start) begin
                    seq_d.ea      = calc_ea;
                    seq_d.opnd    = calc_opnd;
                    seq_d.wdata   = wb_data;
                    seq_d.we_pend = wb_en;
                    if (!need_mem) begin
                        seq_d.done = 1'b1;
                        seq_d.we   = wb_en;
                    end else begin
                        seq_d.st = need_ptr ? S_PTR : S_OPND;
                    end
                end
            end
            S_PTR: begin
                if (mem_ready) begin
                    seq_d.ea = mem_rdata[AW-1:0];
                    seq_d.st = S_OPND;
                end
            end
            S_OPND: begin
                if (mem_ready) begin
                    seq_d.opnd = mem_rdata;
                    seq_d.done = 1'b1;
                    seq_d.we   = seq_q.we_pend;
                    seq_d.st   = S_IDLE;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_req   = (seq_q.st != S_IDLE);
    assign mem_addr  = seq_q.ea;
    assign busy      = (seq_q.st != S_IDLE);
    assign done      = seq_q.done;
    assign ea        = seq_q.ea;
    assign operand   = seq_q.opnd;
    assign reg_we    = seq_q.we;
    assign reg_wdata = seq_q.wdata;

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_wb_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> done);
    assert_no_req_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] addr_field,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] index_reg,
    input  logic [DW-1:0] sel_reg,
    input  logic [DW-1:0] acc,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [DW-1:0] operand,
    output logic          reg_we,
    output logic [DW-1:0] reg_wdata
);
    logic [AW-1:0] calc_ea;
    logic [DW-1:0] calc_opnd;
    logic          need_mem;
    logic          need_ptr;
    logic          wb_en;
    logic [DW-1:0] wb_data;

    ea_addr_calc #(.AW(AW), .DW(DW)) u_calc (
        .mode      (mode),
        .field     (addr_field),
        .pc        (pc),
        .idx       (index_reg),
        .regv      (sel_reg),
        .acc       (acc),
        .calc_ea   (calc_ea),
        .calc_opnd (calc_opnd),
        .need_mem  (need_mem),
        .need_ptr  (need_ptr),
        .wb_en     (wb_en),
        .wb_data   (wb_data)
    );

    ea_sequencer #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .calc_ea   (calc_ea),
        .calc_opnd (calc_opnd),
        .need_mem  (need_mem),
        .need_ptr  (need_ptr),
        .wb_en     (wb_en),
        .wb_data   (wb_data),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .done      (done),
        .ea        (ea),
        .operand   (operand),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata)
    );

    assert_imm_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == M_IMMED) |=>
            (done && !mem_req && operand == DW'($past(addr_field))));
    assert_rel_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == M_RELATIVE) |=>
            (mem_req && mem_addr == AW'($past(pc) + $past(addr_field))));
    assert_idx_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == M_INDEXED) |=>
            (mem_req && mem_addr == AW'($past(index_reg) + $past(addr_field))));
endmodule

// File: tb/ea_unit_test.sv
`timescale 1ns/1ps
module ea_unit_test;
    localparam int AW = 12;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [AW-1:0] addr_field = '0;
    logic [AW-1:0] pc = '0;
    logic [AW-1:0] index_reg = '0;
    logic [DW-1:0] sel_reg = '0;
    logic [DW-1:0] acc = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, reg_we;
    logic [AW-1:0] ea;
    logic [DW-1:0] operand, reg_wdata;

    int checks = 0;
    int fails = 0;
    int pending = 0;
    int lat = 0;
    int wait_cnt = 0;
    int reads = 0;

    logic [AW-1:0] q_ea[$];
    logic [DW-1:0] q_op[$];
    logic          q_we[$];
    logic [DW-1:0] q_wd[$];
    string         q_tag[$];

    always #4 clk = ~clk;

    ea_unit #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_field(addr_field), .pc(pc), .index_reg(index_reg),
        .sel_reg(sel_reg), .acc(acc), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .ea(ea), .operand(operand), .reg_we(reg_we), .reg_wdata(reg_wdata)
    );

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return DW'(int'(a) * 37 + 11);
    endfunction

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // memory model: answers after lat wait cycles
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ready <= 1'b1;
                mem_rdata <= memf(mem_addr);
                wait_cnt  <= 0;
                reads     <= reads + 1;
            end else begin
                mem_ready <= 1'b0;
                wait_cnt  <= wait_cnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
            wait_cnt  <= 0;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_ea.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R10: unexpected done ea=%h op=%h expected none", ea, operand);
            end else begin
                automatic logic [AW-1:0] e_ea = q_ea.pop_front();
                automatic logic [DW-1:0] e_op = q_op.pop_front();
                automatic logic          e_we = q_we.pop_front();
                automatic logic [DW-1:0] e_wd = q_wd.pop_front();
                automatic string         t    = q_tag.pop_front();
                checks++;
                if (ea !== e_ea || operand !== e_op || reg_we !== e_we ||
                    (e_we && reg_wdata !== e_wd)) begin
                    fails++;
                    $display("FAIL %s: ea=%h op=%h we=%b wd=%h expected ea=%h op=%h we=%b wd=%h",
                             t, ea, operand, reg_we, reg_wdata, e_ea, e_op, e_we, e_wd);
                end
                pending--;
            end
        end else if (rst_n) begin
            checks++;
            if (reg_we !== 1'b0) begin
                fails++;
                $display("FAIL R7: reg_we=%b outside done expected 0", reg_we);
            end
        end
    end

    task automatic issue(input logic [3:0] m, input logic [AW-1:0] fld,
                         input logic [AW-1:0] p, input logic [AW-1:0] x,
                         input logic [DW-1:0] r, input logic [DW-1:0] a,
                         input int l, input bit poke, input string tag);
        logic [AW-1:0] e_ea;
        logic [DW-1:0] e_op;
        logic          e_we;
        logic [DW-1:0] e_wd;
        int            e_reads;
        logic [DW-1:0] rm1;
        rm1 = r - DW'(1);
        e_ea = '0; e_op = a; e_we = 1'b0; e_wd = r; e_reads = 1;
        case (m)
            4'd1: begin e_op = DW'(fld); e_reads = 0; end
            4'd2: begin e_op = r; e_reads = 0; end
            4'd3: e_ea = r[AW-1:0];
            4'd4: begin e_ea = r[AW-1:0]; e_we = 1'b1; e_wd = r + DW'(1); end
            4'd5: begin e_ea = rm1[AW-1:0]; e_we = 1'b1; e_wd = rm1; end
            4'd6: e_ea = fld;
            4'd7: begin e_ea = memf(fld); e_reads = 2; end
            4'd8: e_ea = p + fld;
            4'd9: e_ea = x + fld;
            default: e_reads = 0;
        endcase
        if (e_reads > 0) e_op = memf(e_ea);
        q_ea.push_back(e_ea); q_op.push_back(e_op); q_we.push_back(e_we);
        q_wd.push_back(e_wd); q_tag.push_back(tag);
        pending++;
        @(negedge clk);
        lat = l; reads = 0;
        mode = m; addr_field = fld; pc = p; index_reg = x; sel_reg = r; acc = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode = 4'hF; addr_field = ~fld; sel_reg = ~r; pc = ~p; index_reg = ~x;
        if (e_reads == 0) begin
            check(done === 1'b1 && mem_req === 1'b0, "R2",
                  $sformatf("done=%b req=%b one cycle after start expected 1/0", done, mem_req));
        end
        if (poke) begin
            @(negedge clk);
            check(busy === 1'b1, "R9", $sformatf("busy=%b mid-fetch expected 1", busy));
            mode = 4'd1; addr_field = 12'h123; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (pending == 0);
        @(negedge clk);
        check(reads == e_reads, tag, $sformatf("reads=%0d expected %0d", reads, e_reads));
        check(busy === 1'b0, "R9", $sformatf("busy=%b after done expected 0", busy));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0 && reg_we === 1'b0, "R1",
              $sformatf("done=%b busy=%b req=%b we=%b expected 0000", done, busy, mem_req, reg_we));
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R1",
              $sformatf("idle done=%b busy=%b req=%b expected 000", done, busy, mem_req));
        issue(4'd0, 12'd500, 12'd200, 12'd100, 12'd400, 12'h3C5, 0, 0, "R2");
        issue(4'd1, 12'd500, 12'd200, 12'd100, 12'd400, 12'h3C5, 0, 0, "R2");
        issue(4'd2, 12'd500, 12'd200, 12'd100, 12'd400, 12'h3C5, 0, 0, "R2");
        issue(4'd6, 12'd500, 12'd200, 12'd100, 12'd400, 12'h3C5, 2, 0, "R3");
        issue(4'd3, 12'd500, 12'd200, 12'd100, 12'd400, 12'h3C5, 0, 0, "R3");
        issue(4'd7, 12'd500, 12'd200, 12'd100, 12'd400, 12'h3C5, 1, 0, "R4");
        issue(4'd7, 12'd77,  12'd200, 12'd100, 12'd400, 12'h3C5, 4, 1, "R10");
        issue(4'd8, 12'd500, 12'd202, 12'd100, 12'd400, 12'h3C5, 0, 0, "R5");
        issue(4'd8, 12'd200, 12'd4000, 12'd100, 12'd400, 12'h3C5, 3, 0, "R5");
        issue(4'd9, 12'd500, 12'd202, 12'd100, 12'd400, 12'h3C5, 1, 0, "R6");
        issue(4'd9, 12'd2,   12'd202, 12'hFFF, 12'd400, 12'h3C5, 0, 0, "R6");
        issue(4'd4, 12'd500, 12'd202, 12'd100, 12'd400, 12'h3C5, 2, 0, "R7");
        issue(4'd4, 12'd500, 12'd202, 12'd100, 12'hFFF, 12'h3C5, 0, 0, "R7");
        issue(4'd5, 12'd500, 12'd202, 12'd100, 12'd400, 12'h3C5, 1, 0, "R7");
        issue(4'd5, 12'd500, 12'd202, 12'd100, 12'd0,   12'h3C5, 0, 0, "R7");
        issue(4'd12, 12'd500, 12'd202, 12'd100, 12'd400, 12'h0AB, 0, 0, "R10");
        issue(4'd6, 12'd4095, 12'd202, 12'd100, 12'd400, 12'h3C5, 6, 0, "R8");
        issue(4'd7, 12'd9, 12'd202, 12'd100, 12'd400, 12'h3C5, 5, 1, "R8");
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule